// File: doc/BRIEF.md
# Density Vector Prefetch Filter Cache

This block keeps a history of completed density vectors, one bit per cache block of a memory region, and answers mask queries that tell a region prefetcher which blocks of a region are worth fetching. A completed vector is recorded together with its region number. The block places it in a 4-way set-associative history store. Each entry of that store holds the newest and the previous vector of one region. A separate register holds the vector recorded last, whatever its region.

A lookup names a region and a filter policy. The policies are: pass every block, the newest local vector, the OR of the two newest local vectors, or the newest vector from any region. When no history applies, the block returns a default mask of all ones or all zeros, chosen per lookup. The result appears one clock after the request. The prefetcher ANDs this mask with its own candidate set.

Top module: `dv_filter_cache`

## Requirements
- R1: Every cycle with `lkp_valid` high produces exactly one cycle of `res_valid` on the next clock, and `res_valid` is low in every other cycle.
- R2: After synchronous active-low reset, `res_valid` is low and the store holds no history. A lookup of any region then misses in every policy except pass.
- R3: Policy code 2'b01 (last-local): on a hit, `res_mask` is the newest vector recorded for that region and `res_hit` is 1.
- R4: Policy code 2'b10 (or-two): on a hit, `res_mask` is the bitwise OR of the two newest vectors recorded for that region.
- R5: In or-two mode, a region with only one recorded vector returns that vector unchanged.
- R6: Recording a vector for a region already stored makes it the newest vector. The previous newest becomes the older one, and the oldest is dropped.
- R7: Policy code 2'b11 (global): `res_mask` is the vector of the most recent record of any region, with `res_hit` 1. If nothing has been recorded since reset, the default mask is returned with `res_hit` 0.
- R8: Policy code 2'b00 (pass): `res_mask` is all ones and `res_hit` is 0, whatever is stored.
- R9: On a miss, `res_mask` is all ones when `default_ones` was 1 at the request and all zeros when it was 0, and `res_hit` is 0.
- R10: The set index is the low log2(SETS) bits of the region number and the tag is the rest. Four regions of one set coexist. A fifth region of that set evicts the least recently used one.
- R11: A lookup that hits refreshes its entry's recency. A record refreshes its entry too. A miss does not refresh anything.
- R12: When a record and a lookup occur in the same cycle, the lookup returns the state from before that record. This holds both for a region already stored and for a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Record a completed vector this cycle |
| rec_region | input | REGION_W | Region number of the recorded vector |
| rec_vec | input | VEC_W | Completed density vector |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_region | input | REGION_W | Region being looked up |
| lkp_policy | input | 2 | Filter policy: 00 pass, 01 last-local, 10 or-two, 11 global |
| default_ones | input | 1 | Miss default: 1 gives all ones, 0 gives all zeros |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Mask was taken from stored history |
| res_mask | output | VEC_W | Predicted-useful block mask |

## Verification
The record path and the lookup path can both be active in the same cycle and can target the same region. The bench drives both in one cycle, first on a region already stored and then on a region not yet stored. It expects the pre-record answer in that cycle: the old newest vector for the stored region and a default miss for the new one. A following lookup must then show the new vector. Recency updates from lookups and records in the same set are also interleaved. The choice of evicted region then shows whether each update was counted.

// File: rtl/dvf_pkg.sv
// Package: shared types of the density vector filter cache.
package dvf_pkg;
    // Filter policy encoding as seen on the lkp_policy port.
    typedef enum logic [1:0] {
        POL_PASS   = 2'b00,
        POL_LAST   = 2'b01,
        POL_OR2    = 2'b10,
        POL_GLOBAL = 2'b11
    } dvf_policy_e;
endpackage

// File: rtl/dvf_lru.sv
// Module: dvf_lru
// Keeps a full recency rank per set (0 = most recent, WAYS-1 = least recent).
// Up to two touches per cycle are supported: the lookup touch is applied first,
// then the record touch, so a record in the same set ends up most recent.
// Assumes WAYS is a power of two and at least 2. Reset loads rank = way index,
// a valid permutation, so the victim of an empty set is always an unused way.
module dvf_lru #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_touch,
    input  logic [SET_W-1:0] lkp_set,
    input  logic [WAY_W-1:0] lkp_way,
    input  logic             rec_touch,
    input  logic [SET_W-1:0] rec_set,
    input  logic [WAY_W-1:0] rec_way,
    output logic [WAY_W-1:0] victim_way
);
    typedef logic [WAYS-1:0][WAY_W-1:0] rank_row_t;

    rank_row_t rank_q [SETS];
    rank_row_t rank_d [SETS];

    // Promote one way to most recent and age every way that was more recent.
    function automatic rank_row_t promote(rank_row_t row, logic [WAY_W-1:0] way);
        rank_row_t res;
        res = row;
        for (int i = 0; i < WAYS; i++) begin
            if (row[i] < row[way]) begin
                res[i] = row[i] + 1'b1;
            end
        end
        res[way] = '0;
        return res;
    endfunction

    // Next-state ranks: lookup touch first, record touch second.
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            rank_d[s] = rank_q[s];
            if (lkp_touch && (lkp_set == SET_W'(s))) begin
                rank_d[s] = promote(rank_d[s], lkp_way);
            end
            if (rec_touch && (rec_set == SET_W'(s))) begin
                rank_d[s] = promote(rank_d[s], rec_way);
            end
        end
    end

    // Rank registers with reset to the identity permutation.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!rst_n) begin
                    rank_q[s][w] <= WAY_W'(w);
                end else begin
                    rank_q[s][w] <= rank_d[s][w];
                end
            end
        end
    end

    // Victim of the record set is the way holding the oldest rank.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[rec_set][w] == WAY_W'(WAYS - 1)) begin
                victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/dvf_way_array.sv
// Module: dvf_way_array
// Tag, valid and two-vector storage of the set-associative history store.
// Read side: combinational tag match for the lookup set and for the record set.
// Write side: a record that hits shifts newer into older and stores the new
// vector as newer; a record that misses claims victim_way and clears older, so
// an entry with one recorded vector reads back zero in its older slot.
// Only valid bits are reset; tags and vectors are written before first use.
module dvf_way_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int VEC_W = 64,
    parameter int TAG_W = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lkp_set,
    input  logic [TAG_W-1:0] lkp_tag,
    output logic             lkp_hit,
    output logic [WAY_W-1:0] lkp_way,
    output logic [VEC_W-1:0] lkp_newer,
    output logic [VEC_W-1:0] lkp_older,
    input  logic             rec_valid,
    input  logic [SET_W-1:0] rec_set,
    input  logic [TAG_W-1:0] rec_tag,
    input  logic [VEC_W-1:0] rec_vec,
    input  logic [WAY_W-1:0] victim_way,
    output logic             rec_hit,
    output logic [WAY_W-1:0] rec_way
);
    logic [WAYS-1:0] valid_q [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [VEC_W-1:0] newer_q [SETS][WAYS];
    logic [VEC_W-1:0] older_q [SETS][WAYS];

    logic [WAYS-1:0] lkp_match;
    logic [WAYS-1:0] rec_match;
    logic [WAY_W-1:0] rec_hit_way;

    // Per-way tag comparators for both ports.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lkp_match[w] = valid_q[lkp_set][w] && (tag_q[lkp_set][w] == lkp_tag);
        assign rec_match[w] = valid_q[rec_set][w] && (tag_q[rec_set][w] == rec_tag);
    end

    // Encode matching ways (tags within a set are unique, so at most one).
    always_comb begin
        lkp_way     = '0;
        rec_hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lkp_match[w]) lkp_way = WAY_W'(w);
            if (rec_match[w]) rec_hit_way = WAY_W'(w);
        end
    end

    assign lkp_hit   = |lkp_match;
    assign rec_hit   = |rec_match;
    assign rec_way   = rec_hit ? rec_hit_way : victim_way;
    assign lkp_newer = newer_q[lkp_set][lkp_way];
    assign lkp_older = older_q[lkp_set][lkp_way];

    // Valid bits: cleared by reset, set when a way is claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (rec_valid) begin
            valid_q[rec_set][rec_way] <= 1'b1;
        end
    end

    // Tag and vector slots: shift on hit, fill on miss.
    always_ff @(posedge clk) begin
        if (rec_valid) begin
            if (rec_hit) begin
                older_q[rec_set][rec_way] <= newer_q[rec_set][rec_way];
            end else begin
                older_q[rec_set][rec_way] <= '0;
                tag_q[rec_set][rec_way]   <= rec_tag;
            end
            newer_q[rec_set][rec_way] <= rec_vec;
        end
    end
endmodule

// File: rtl/dvf_mask_sel.sv
// Module: dvf_mask_sel
// Combinational policy mux: turns the lookup's tag result, the two local
// vectors and the global vector into the filter mask and a history flag.
// Assumes older is zero for an entry holding a single vector.
module dvf_mask_sel
    import dvf_pkg::*;
#(
    parameter int VEC_W = 64
) (
    input  dvf_policy_e      policy,
    input  logic             tag_hit,
    input  logic [VEC_W-1:0] newer,
    input  logic [VEC_W-1:0] older,
    input  logic             glob_valid,
    input  logic [VEC_W-1:0] glob_vec,
    input  logic             default_ones,
    output logic [VEC_W-1:0] mask,
    output logic             from_history
);
    logic [VEC_W-1:0] dflt_mask;

    assign dflt_mask = {VEC_W{default_ones}};

    // Select the mask source for the requested policy.
    always_comb begin
        mask         = dflt_mask;
        from_history = 1'b0;
        unique case (policy)
            POL_PASS: begin
                mask = '1;
            end
            POL_LAST: begin
                if (tag_hit) begin
                    mask         = newer;
                    from_history = 1'b1;
                end
            end
            POL_OR2: begin
                if (tag_hit) begin
                    mask         = newer | older;
                    from_history = 1'b1;
                end
            end
            POL_GLOBAL: begin
                if (glob_valid) begin
                    mask         = glob_vec;
                    from_history = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dv_filter_cache.sv
// Module: dv_filter_cache (top)
// Density vector history cache with a one-cycle lookup. The region number is
// split into a set index (low bits) and a tag (high bits). State is read
// combinationally in the request cycle and the answer is registered, so a
// record in the same cycle is seen only by later lookups. Assumes
// REGION_W > log2(SETS) and WAYS a power of two of at least 2.
module dv_filter_cache
    import dvf_pkg::*;
#(
    parameter int VEC_W    = 64,
    parameter int REGION_W = 20,
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int TAG_W   = REGION_W - SET_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_valid,
    input  logic [REGION_W-1:0] rec_region,
    input  logic [VEC_W-1:0]    rec_vec,
    input  logic                lkp_valid,
    input  logic [REGION_W-1:0] lkp_region,
    input  logic [1:0]          lkp_policy,
    input  logic                default_ones,
    output logic                res_valid,
    output logic                res_hit,
    output logic [VEC_W-1:0]    res_mask
);
    logic [SET_W-1:0] lkp_set, rec_set;
    logic [TAG_W-1:0] lkp_tag, rec_tag;
    logic             lkp_hit, rec_hit;
    logic [WAY_W-1:0] lkp_way, rec_way, victim_way;
    logic [VEC_W-1:0] lkp_newer, lkp_older;
    logic             glob_valid_q;
    logic [VEC_W-1:0] glob_vec_q;
    logic [VEC_W-1:0] sel_mask;
    logic             sel_hist;
    dvf_policy_e      policy;

    assign lkp_set = lkp_region[SET_W-1:0];
    assign lkp_tag = lkp_region[REGION_W-1:SET_W];
    assign rec_set = rec_region[SET_W-1:0];
    assign rec_tag = rec_region[REGION_W-1:SET_W];
    assign policy  = dvf_policy_e'(lkp_policy);

    dvf_way_array #(
        .SETS (SETS),
        .WAYS (WAYS),
        .VEC_W(VEC_W),
        .TAG_W(TAG_W)
    ) i_ways (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_set   (lkp_set),
        .lkp_tag   (lkp_tag),
        .lkp_hit   (lkp_hit),
        .lkp_way   (lkp_way),
        .lkp_newer (lkp_newer),
        .lkp_older (lkp_older),
        .rec_valid (rec_valid),
        .rec_set   (rec_set),
        .rec_tag   (rec_tag),
        .rec_vec   (rec_vec),
        .victim_way(victim_way),
        .rec_hit   (rec_hit),
        .rec_way   (rec_way)
    );

    dvf_lru #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_touch (lkp_valid && lkp_hit),
        .lkp_set   (lkp_set),
        .lkp_way   (lkp_way),
        .rec_touch (rec_valid),
        .rec_set   (rec_set),
        .rec_way   (rec_way),
        .victim_way(victim_way)
    );

    dvf_mask_sel #(
        .VEC_W(VEC_W)
    ) i_sel (
        .policy      (policy),
        .tag_hit     (lkp_hit),
        .newer       (lkp_newer),
        .older       (lkp_older),
        .glob_valid  (glob_valid_q),
        .glob_vec    (glob_vec_q),
        .default_ones(default_ones),
        .mask        (sel_mask),
        .from_history(sel_hist)
    );

    // Global register: the vector of the latest record from any region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_valid_q <= 1'b0;
            glob_vec_q   <= '0;
        end else if (rec_valid) begin
            glob_valid_q <= 1'b1;
            glob_vec_q   <= rec_vec;
        end
    end

    // Result register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_mask  <= '0;
        end else begin
            res_valid <= lkp_valid;
            if (lkp_valid) begin
                res_hit  <= sel_hist;
                res_mask <= sel_mask;
            end
        end
    end
endmodule

// File: rtl/dvf_filter_chk.sv
// Module: dvf_filter_chk
// Port-level checker bound to dv_filter_cache. Keeps its own copy of the last
// recorded vector to judge global-mode answers.
module dvf_filter_chk #(
    parameter int VEC_W    = 64,
    parameter int REGION_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rec_valid,
    input logic [VEC_W-1:0]    rec_vec,
    input logic                lkp_valid,
    input logic [1:0]          lkp_policy,
    input logic                default_ones,
    input logic                res_valid,
    input logic                res_hit,
    input logic [VEC_W-1:0]    res_mask
);
    logic             seen_q;
    logic [VEC_W-1:0] last_vec_q;

    // Observed latest record, independent of the design's own register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_vec_q <= '0;
        end else if (rec_valid) begin
            seen_q     <= 1'b1;
            last_vec_q <= rec_vec;
        end
    end

    // R1
    res_follows_lkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> res_valid);

    // R1
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !res_valid);

    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R8
    pass_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_policy == 2'b00) |=> (res_mask == {VEC_W{1'b1}} && !res_hit));

    // R9
    miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_policy != 2'b00) |=> (res_hit || res_mask == {VEC_W{$past(default_ones)}}));

    // R7
    global_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_policy == 2'b11 && seen_q) |=> (res_hit && res_mask == $past(last_vec_q)));
endmodule

bind dv_filter_cache dvf_filter_chk #(
    .VEC_W   (VEC_W),
    .REGION_W(REGION_W)
) i_dvf_filter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rec_valid   (rec_valid),
    .rec_vec     (rec_vec),
    .lkp_valid   (lkp_valid),
    .lkp_policy  (lkp_policy),
    .default_ones(default_ones),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_mask    (res_mask)
);

// File: tb/test_dv_filter_cache.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected results, a monitor compares.
module test_dv_filter_cache;
    localparam int VEC_W    = 64;
    localparam int REGION_W = 20;

    localparam logic [1:0] P_PASS = 2'b00;
    localparam logic [1:0] P_LAST = 2'b01;
    localparam logic [1:0] P_OR2  = 2'b10;
    localparam logic [1:0] P_GLOB = 2'b11;
    localparam logic [VEC_W-1:0] ONES  = '1;
    localparam logic [VEC_W-1:0] ZEROS = '0;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rec_valid = 1'b0;
    logic [REGION_W-1:0] rec_region = '0;
    logic [VEC_W-1:0]    rec_vec = '0;
    logic                lkp_valid = 1'b0;
    logic [REGION_W-1:0] lkp_region = '0;
    logic [1:0]          lkp_policy = '0;
    logic                default_ones = 1'b0;
    logic                res_valid;
    logic                res_hit;
    logic [VEC_W-1:0]    res_mask;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [VEC_W:0] exp_q [$];
    string          tag_q [$];

    always #2 clk = ~clk;

    dv_filter_cache #(
        .VEC_W   (VEC_W),
        .REGION_W(REGION_W)
    ) i_dv_filter_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_valid   (rec_valid),
        .rec_region  (rec_region),
        .rec_vec     (rec_vec),
        .lkp_valid   (lkp_valid),
        .lkp_region  (lkp_region),
        .lkp_policy  (lkp_policy),
        .default_ones(default_ones),
        .res_valid   (res_valid),
        .res_hit     (res_hit),
        .res_mask    (res_mask)
    );

    // Record one vector during one cycle.
    task automatic do_rec(input int region, input logic [VEC_W-1:0] vec);
        rec_valid  = 1'b1;
        rec_region = REGION_W'(region);
        rec_vec    = vec;
        @(negedge clk);
        rec_valid  = 1'b0;
    endtask

    // Issue one lookup and queue its expected answer.
    task automatic do_lkp(input int region, input logic [1:0] pol, input logic dflt,
                          input logic eh, input logic [VEC_W-1:0] em, input string req);
        lkp_valid    = 1'b1;
        lkp_region   = REGION_W'(region);
        lkp_policy   = pol;
        default_ones = dflt;
        exp_q.push_back({eh, em});
        tag_q.push_back(req);
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    // Record and lookup in the same cycle.
    task automatic do_both(input int region, input logic [VEC_W-1:0] vec, input logic [1:0] pol,
                           input logic dflt, input logic eh, input logic [VEC_W-1:0] em,
                           input string req);
        rec_valid  = 1'b1;
        rec_region = REGION_W'(region);
        rec_vec    = vec;
        do_lkp(region, pol, dflt, eh, em, req);
        rec_valid  = 1'b0;
    endtask

    // Monitor: compare each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected result hit=%0b mask=%h, expected none", res_hit, res_mask);
            end else begin
                logic [VEC_W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_hit, res_mask} !== e) begin
                    errors++;
                    $display("FAIL %s: hit=%0b mask=%h, expected hit=%0b mask=%h",
                             t, res_hit, res_mask, e[VEC_W], e[VEC_W-1:0]);
                end
            end
        end
    end

    localparam logic [VEC_W-1:0] VA = 64'h0000_0000_0000_00F0;
    localparam logic [VEC_W-1:0] VB = 64'h0000_0000_0F00_0001;
    localparam logic [VEC_W-1:0] VC = 64'h8000_0000_0000_0100;
    localparam logic [VEC_W-1:0] VD = 64'h0123_4567_89AB_CDEF;
    localparam logic [VEC_W-1:0] VF = 64'h0000_FFFF_0000_0000;
    localparam logic [VEC_W-1:0] VG = 64'h00F0_0000_0000_F000;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: res_valid=%0b in reset, expected 0", res_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R9 / R7: empty store misses, default selects the mask.
        do_lkp(5, P_LAST, 1'b1, 1'b0, ONES,  "R2");
        do_lkp(5, P_OR2,  1'b0, 1'b0, ZEROS, "R9");
        do_lkp(5, P_GLOB, 1'b0, 1'b0, ZEROS, "R7");
        do_lkp(5, P_GLOB, 1'b1, 1'b0, ONES,  "R9");

        // R3 / R5: single recorded vector.
        do_rec(5, VA);
        do_lkp(5, P_LAST, 1'b0, 1'b1, VA, "R3");
        do_lkp(5, P_OR2,  1'b0, 1'b1, VA, "R5");

        // R4 / R6: two and three records for one region.
        do_rec(5, VB);
        do_lkp(5, P_LAST, 1'b0, 1'b1, VB,      "R3");
        do_lkp(5, P_OR2,  1'b1, 1'b1, VA | VB, "R4");
        do_rec(5, VC);
        do_lkp(5, P_OR2,  1'b0, 1'b1, VB | VC, "R6");

        // R7: global mode follows the latest record of any region.
        do_lkp(5, P_GLOB, 1'b0, 1'b1, VC, "R7");
        do_rec(9, VD);
        do_lkp(5, P_GLOB, 1'b0, 1'b1, VD, "R7");
        do_lkp(9, P_LAST, 1'b0, 1'b1, VD, "R3");

        // R8: pass mode ignores history.
        do_lkp(5, P_PASS, 1'b0, 1'b0, ONES, "R8");

        // R10: fill set 4, a fifth region evicts the oldest (region 4).
        for (int k = 0; k < 4; k++) do_rec(4 + 16 * k, VEC_W'(64'h11) << (8 * k));
        do_rec(68, VG);
        do_lkp(4,  P_LAST, 1'b0, 1'b0, ZEROS, "R10");
        do_lkp(20, P_LAST, 1'b0, 1'b1, VEC_W'(64'h11) << 8, "R10");
        do_lkp(68, P_LAST, 1'b0, 1'b1, VG, "R10");

        // R11: a hitting lookup protects region 3; region 19 is evicted instead.
        for (int k = 0; k < 4; k++) do_rec(3 + 16 * k, VEC_W'(64'h3) << (4 * k));
        do_lkp(3, P_LAST, 1'b0, 1'b1, VEC_W'(64'h3), "R11");
        do_rec(67, VG);
        do_lkp(19, P_LAST, 1'b0, 1'b0, ZEROS, "R11");
        do_lkp(3,  P_LAST, 1'b0, 1'b1, VEC_W'(64'h3), "R11");
        do_lkp(35, P_LAST, 1'b0, 1'b1, VEC_W'(64'h3) << 8, "R11");
        do_lkp(51, P_OR2,  1'b0, 1'b1, VEC_W'(64'h3) << 12, "R11");

        // R12: same-cycle record and lookup see the old state.
        do_both(5, VF, P_LAST, 1'b0, 1'b1, VC, "R12");
        do_lkp(5, P_OR2, 1'b0, 1'b1, VF | VC, "R12");
        do_both(7, VA, P_LAST, 1'b1, 1'b0, ONES, "R12");
        do_lkp(7, P_LAST, 1'b0, 1'b1, VA, "R12");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, actual running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule